// File: doc/BRIEF.md
# Partitioned Packed SIMD ALU

A 64-bit arithmetic and logic unit that treats each operand as a row of packed sub-words and applies one operation to every sub-word in the same cycle. A two-bit width selector splits the word into eight 8-bit, four 16-bit or two 32-bit lanes. The adder's carry chain is cut at the lane boundaries that this selector chooses. A fourth setting treats the word as one 64-bit quantity, but only for bitwise and shift operations. Adding, subtracting or comparing a full 64-bit word is not supported. A request for it is flagged as illegal and returns zero.

A request is presented with `in_valid`, and its result appears one clock later with `out_valid`. The output side has a two-state machine. `ST_IDLE` means no fresh result. `ST_VALID` means a result was captured on the last edge. The machine moves to `ST_VALID` on any cycle with `in_valid` high and to `ST_IDLE` on any cycle without it. The result and the illegal flag keep their values while no request arrives.

Top module: `simd_alu`

Operation codes on `op`: 0 add, 1 subtract, 2 signed greater-than, 3 AND, 4 OR, 5 XOR, 6 logical shift left, 7 logical shift right. Width codes on `mode`: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes, 3 gives one 64-bit word.

## Requirements
- R1: While reset is asserted and after it is released, with no request yet made, `out_valid`, `result` and `illegal` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: Add (op 0) with mode 0, 1 or 2 gives each lane's sum modulo 2^lanewidth, and no carry passes from one lane to the next.
- R4: Subtract (op 1) with mode 0, 1 or 2 gives each lane's A minus B modulo 2^lanewidth, and no borrow passes between lanes.
- R5: Greater-than (op 2) with mode 0, 1 or 2 sets a result lane to all ones when the signed A lane is greater than the signed B lane, and to all zeros otherwise.
- R6: AND, OR and XOR (ops 3, 4, 5) act on the whole 64-bit word and give the same result for every mode.
- R7: Shift left (op 6) shifts each lane independently by `shamt` with zero fill. In mode 3 it shifts the whole 64-bit word.
- R8: Shift right (op 7) is logical: each lane, or the whole word in mode 3, is shifted independently with zero fill from the top.
- R9: A shift amount equal to or greater than the lane width (64 in mode 3) gives zero in that lane.
- R10: Ops 0, 1 and 2 with mode 3 return a zero result with `illegal` high. Every other operation returns `illegal` low.
- R11: In a cycle without `in_valid`, the next `result` and `illegal` equal the current ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| mode | input | 2 | Lane width selector |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| shamt | input | 7 | Shift amount for ops 6 and 7 |
| out_valid | output | 1 | Result captured on the last edge |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-request flag |

## Verification
The bench builds the block with its default parameters: a 64-bit word and 8-bit basic segments. These reach all four lane widths, including the full-word shift path and the illegal full-word arithmetic path. Fixed vectors place carries, borrows and sign bits exactly on lane edges. They also use shift amounts one below the lane width and exactly at it. A seeded random stream then covers every operation and width pair back to back, so that the one-cycle pipeline is kept full.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMPGT = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_SLL   = 3'd6,
        OP_SRL   = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LANES_8    = 2'd0,
        LANES_16   = 2'd1,
        LANES_32   = 2'd2,
        LANES_FULL = 2'd3
    } lane_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
    parameter int W   = 64,
    parameter int SEG = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic [1:0]   mode,
    output logic [W-1:0] sum
);
    localparam int NSEG = W / SEG;

    logic [NSEG-1:0] cout;
    logic [NSEG-1:0] cin;
    logic [NSEG-1:0] brk;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [SEG:0] part;
        assign brk[s] = (s == 0) || (mode == 2'd0)
                      || ((mode == 2'd1) && (s % 2 == 0))
                      || ((mode == 2'd2) && (s % 4 == 0));
        if (s == 0) begin : g_first
            assign cin[s] = sub;
        end else begin : g_rest
            assign cin[s] = brk[s] ? sub : cout[s-1];
        end
        assign part = {1'b0, a[s*SEG +: SEG]}
                    + {1'b0, b[s*SEG +: SEG] ^ {SEG{sub}}}
                    + {{SEG{1'b0}}, cin[s]};
        assign sum[s*SEG +: SEG] = part[SEG-1:0];
        assign cout[s] = part[SEG];
    end

    // The lowest segment always starts a lane, so it is a plain wrap of A op B (R3, R4)
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            assert_low_lane_wrap_R3: assert (sum[SEG-1:0] ==
                (sub ? SEG'(a[SEG-1:0] - b[SEG-1:0]) : SEG'(a[SEG-1:0] + b[SEG-1:0])));
        end
    end
endmodule

// File: rtl/simd_cmp.sv
module simd_cmp #(
    parameter int W   = 64,
    parameter int SEG = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   mode,
    output logic [W-1:0] gt
);
    localparam int NW = $clog2(W / SEG) + 1;

    logic [NW-1:0][W-1:0] res;

    for (genvar k = 0; k < NW; k++) begin : g_width
        localparam int LW = SEG << k;
        for (genvar l = 0; l < W / LW; l++) begin : g_lane
            assign res[k][l*LW +: LW] =
                ($signed(a[l*LW +: LW]) > $signed(b[l*LW +: LW])) ? {LW{1'b1}} : {LW{1'b0}};
        end
    end

    assign gt = res[mode];
endmodule

// File: rtl/simd_shift.sv
module simd_shift #(
    parameter int W   = 64,
    parameter int SEG = 8,
    parameter int SHW = $clog2(W) + 1
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] shamt,
    input  logic           right,
    input  logic [1:0]     mode,
    output logic [W-1:0]   y
);
    localparam int NW = $clog2(W / SEG) + 1;

    logic [NW-1:0][W-1:0] res;

    for (genvar k = 0; k < NW; k++) begin : g_width
        localparam int LW = SEG << k;
        localparam logic [SHW-1:0] LW_S = SHW'(LW);
        for (genvar l = 0; l < W / LW; l++) begin : g_lane
            logic [LW-1:0] lane;
            assign lane = a[l*LW +: LW];
            assign res[k][l*LW +: LW] = (shamt >= LW_S) ? {LW{1'b0}}
                                      : (right ? (lane >> shamt) : (lane << shamt));
        end
    end

    assign y = res[mode];
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int W   = 64,
    parameter int SEG = 8,
    parameter int SHW = $clog2(W) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     op,
    input  logic [1:0]     mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] shamt,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           illegal
);
    alu_op_e    op_e;
    lane_mode_e mode_e;
    out_state_e state_q, state_d;

    logic [W-1:0] sum_w, gt_w, sh_w, res_c;
    logic         arith_c, ill_c;

    assign op_e   = alu_op_e'(op);
    assign mode_e = lane_mode_e'(mode);

    simd_addsub #(.W(W), .SEG(SEG)) i_addsub (
        .a(a), .b(b), .sub(op_e == OP_SUB), .mode(mode), .sum(sum_w)
    );

    simd_cmp #(.W(W), .SEG(SEG)) i_cmp (
        .a(a), .b(b), .mode(mode), .gt(gt_w)
    );

    simd_shift #(.W(W), .SEG(SEG), .SHW(SHW)) i_shift (
        .a(a), .shamt(shamt), .right(op_e == OP_SRL), .mode(mode), .y(sh_w)
    );

    assign arith_c = (op_e == OP_ADD) || (op_e == OP_SUB) || (op_e == OP_CMPGT);
    assign ill_c   = arith_c && (mode_e == LANES_FULL);

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: res_c = sum_w;
            OP_CMPGT:       res_c = gt_w;
            OP_AND:         res_c = a & b;
            OP_OR:          res_c = a | b;
            OP_XOR:         res_c = a ^ b;
            OP_SLL, OP_SRL: res_c = sh_w;
            default:        res_c = '0;
        endcase
        if (ill_c) res_c = '0;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= res_c;
            illegal <= ill_c;
        end
    end

    assign out_valid = (state_q == ST_VALID);

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));
    assert_legal_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 2'd3) |=> !illegal);
    assert_cmp_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && mode != 2'd3) |=>
        (result[SEG-1:0] == '0 || result[SEG-1:0] == '1));
endmodule

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  mode = '0;
    logic [63:0] a = '0, b = '0;
    logic [6:0]  shamt = '0;
    logic        out_valid, illegal;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [63:0] r;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [63:0] last_r;
    logic        last_ill;

    always #2.5 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
        .a(a), .b(b), .shamt(shamt), .out_valid(out_valid), .result(result),
        .illegal(illegal)
    );

    function automatic logic [63:0] model(input logic [2:0] o, input logic [1:0] m,
                                          input logic [63:0] x, input logic [63:0] y,
                                          input logic [6:0] s, output logic ill);
        int lw;
        logic [63:0] mask, res, lx, ly, lr, sb_bit;
        lw = 8 << m;
        mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 1);
        sb_bit = 64'd1 << (lw - 1);
        ill = (o <= 3'd2) && (m == 2'd3);
        if (ill) return 64'd0;
        if (o == 3'd3) return x & y;
        if (o == 3'd4) return x | y;
        if (o == 3'd5) return x ^ y;
        res = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            lx = (x >> (i * lw)) & mask;
            ly = (y >> (i * lw)) & mask;
            case (o)
                3'd0: lr = lx + ly;
                3'd1: lr = lx - ly;
                3'd2: lr = ((lx ^ sb_bit) > (ly ^ sb_bit)) ? mask : 64'd0;
                3'd6: lr = (int'(s) >= lw) ? 64'd0 : (lx << s);
                default: lr = (int'(s) >= lw) ? 64'd0 : (lx >> s);
            endcase
            res = res | ((lr & mask) << (i * lw));
        end
        return res;
    endfunction

    task automatic drive(input logic [2:0] o, input logic [1:0] m, input logic [63:0] x,
                         input logic [63:0] y, input logic [6:0] s,
                         input logic [63:0] er, input logic eil, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; mode = m; a = x; b = y; shamt = s;
        e.r = er; e.ill = eil; e.tag = tag;
        sb.push_back(e);
        last_r = er; last_ill = eil;
    endtask

    task automatic drive_m(input logic [2:0] o, input logic [1:0] m, input logic [63:0] x,
                           input logic [63:0] y, input logic [6:0] s, input string tag);
        logic il;
        logic [63:0] r;
        r = model(o, m, x, y, s, il);
        drive(o, m, x, y, s, r, il, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
            end else begin
                e = sb.pop_front();
                if (result !== e.r || illegal !== e.ill) begin
                    n_fail++;
                    $display("FAIL %s: actual %h/%b expected %h/%b", e.tag, result, illegal,
                             e.r, e.ill);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || result !== 64'd0 || illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual %b/%h/%b expected 0/0/0", out_valid, result, illegal);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || result !== 64'd0) begin
            n_fail++;
            $display("FAIL R1: after release actual %b/%h expected 0/0", out_valid, result);
        end

        drive(3'd0, 2'd0, 64'hFF, 64'h01, 7'd0, 64'h0, 1'b0, "R3 add8 no carry");
        drive(3'd0, 2'd1, 64'hFF, 64'h01, 7'd0, 64'h100, 1'b0, "R3 add16 inner carry");
        drive(3'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'd0, 64'hFFFF_FFFF_0000_0000, 1'b0,
              "R3 add32 lane edge");
        drive(3'd1, 2'd0, 64'h0, 64'h1, 7'd0, 64'hFF, 1'b0, "R4 sub8 borrow stops");
        drive(3'd1, 2'd1, 64'h0, 64'h1, 7'd0, 64'hFFFF, 1'b0, "R4 sub16 borrow stops");
        drive(3'd2, 2'd0, 64'h0180, 64'h0001, 7'd0, 64'hFF00, 1'b0, "R5 cmp8 signed");
        drive(3'd2, 2'd1, 64'h7F01, 64'h80FF, 7'd0, 64'hFFFF, 1'b0, "R5 cmp16 signed");
        drive(3'd3, 2'd3, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FFFF_0F0F_FFFF, 7'd0,
              64'hF000_0000_0F0F_1234, 1'b0, "R6 and full");
        drive(3'd5, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 7'd0,
              64'h0FF0_0FF0_0FF0_0FF0, 1'b0, "R6 xor mode0");
        drive(3'd6, 2'd0, 64'h8181_8181_8181_8181, 64'h0, 7'd1, 64'h0202_0202_0202_0202, 1'b0,
              "R7 sll8");
        drive(3'd6, 2'd3, 64'h8181_8181_8181_8181, 64'h0, 7'd1, 64'h0303_0303_0303_0302, 1'b0,
              "R7 sll full");
        drive(3'd7, 2'd1, 64'h8000_8000_8000_8000, 64'h0, 7'd15, 64'h0001_0001_0001_0001, 1'b0,
              "R8 srl16 by 15");
        drive(3'd7, 2'd3, 64'h8000_0000_0000_0000, 64'h0, 7'd63, 64'h1, 1'b0, "R8 srl full 63");
        drive(3'd7, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd16, 64'h0, 1'b0, "R9 srl16 by 16");
        drive(3'd6, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd64, 64'h0, 1'b0, "R9 sll full 64");
        drive(3'd0, 2'd3, 64'h1234, 64'h1, 7'd0, 64'h0, 1'b1, "R10 add full illegal");
        drive(3'd2, 2'd3, 64'h5, 64'h1, 7'd0, 64'h0, 1'b1, "R10 cmp full illegal");
        drive(3'd4, 2'd3, 64'hA0, 64'h05, 7'd0, 64'hA5, 1'b0, "R10 legal clears flag");
        drive(3'd0, 2'd3, 64'h1, 64'h1, 7'd0, 64'h0, 1'b1, "R10 illegal again");
        idle();
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || result !== last_r || illegal !== last_ill) begin
            n_fail++;
            $display("FAIL R11: actual %b/%h/%b expected 0/%h/%b", out_valid, result, illegal,
                     last_r, last_ill);
        end

        for (int i = 0; i < 400; i++) begin
            logic [2:0] o;
            logic [1:0] m;
            logic [6:0] s;
            o = 3'($urandom_range(0, 7));
            m = 2'($urandom_range(0, 3));
            s = 7'($urandom_range(0, 70));
            drive_m(o, m, {$urandom, $urandom}, {$urandom, $urandom}, s, "R3 R4 R5 R6 R7 R8 random");
            if (i % 37 == 0) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: results missing actual %0d expected 0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule